// File: doc/BRIEF.md
# Parallel I/O Port with Shared-Pin Change Interrupts

This block is a parallel port of up to twelve pins (parameter `NPINS`) driven through a small register interface. Each pin works in one of three ways:

- as a general-purpose input;
- as a general-purpose output driven from an output latch;
- handed over to an on-chip serial controller, whose flow-control inputs (clear-to-send, carrier-detect) read the pin level.

A special-option bit lets a general-purpose input pin feed the serial controller and still raise change interrupts. The controller then gets its control signal automatically, and software can also see every transition on it.

Pin levels pass through a two-flop synchronizer before they are read back or checked for edges. For each pin, an edge-control bit picks the edges that count: any change, or falling edges only. A qualifying edge sets a sticky pending bit. A mask register decides which pending bits drive the single combined interrupt output. Software clears pending bits by writing ones to them.

The bus is single-cycle. A write takes effect at the rising clock edge while `bus_wr` is high. Read data is combinational from `bus_addr`. There is no state machine: the block is a register file with per-pin pipelines.

Top module: `gpio_port`

## Requirements
- R1: After reset, every register (data latch, direction, assignment, special option, edge control, mask, pending) is zero. `pin_oe` is zero and `irq` is low.
- R2: A pin is driven (`pin_oe` bit = 1) only when its direction bit is 1 and its assignment bit is 0. `pin_out` always carries the output latch.
- R3: A write to the data address updates the output latch even for non-driven pins. Once the pin is made a driven output, it shows the latch value.
- R4: A read of the data address (0) returns the latch bit for driven output pins. For every other pin, including pins assigned to the peripheral, it returns the synchronized pin level. A pin change shows up in this read after two rising clock edges.
- R5: `periph_in` carries the synchronized pin level for pins whose assignment bit is 1, and for general-purpose input pins whose special-option bit is 1. All other bits are 0.
- R6: Only pins with assignment 0 and direction 0 can set pending bits. The special-option bit does not block this, and an assignment bit of 1 or a direction bit of 1 does.
- R7: Edge-control bit 0 selects both edges and bit 1 selects falling edges only. A qualifying pin change is visible in the pending bit after three rising clock edges.
- R8: Pending bits stay set until a one is written to them at the pending address (6). Written zeros leave them unchanged. A set and a clear of the same bit in the same cycle leave it set.
- R9: `irq` is the OR over all pins of pending AND mask. The mask does not stop pending bits from setting.
- R10: Register addresses are 0 data, 1 direction, 2 assignment, 3 special option, 4 edge control, 5 mask, 6 pending. Address 7 reads as zero, and writes to it change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, sampled at the rising edge |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | NPINS | Write data |
| bus_rdata | output | NPINS | Combinational read data |
| pin_in | input | NPINS | Pad input levels |
| pin_out | output | NPINS | Output latch toward the pads |
| pin_oe | output | NPINS | Pad drive enables |
| periph_in | output | NPINS | Synchronized levels routed to the serial controller |
| irq | output | 1 | Combined masked interrupt |

## Verification
The stimulus is random register settings with random pin patterns. Each pattern changes every pin at most once, so the expected pending bits follow from the old and new levels under the edge mode that was drawn. This separates three cases:

- eligible pins from assigned or driven ones;
- both-edge mode from falling-only mode;
- special-option pins from plain inputs.

Random clear patterns show whether clears touch only the written bits. A directed case lines up a clear with a new edge in the same cycle, to test that set wins. Other directed cases cover the unused address and the latch value written while a pin is still an input.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
    localparam int ADDR_W = 3;

    typedef enum logic [ADDR_W-1:0] {
        REG_DATA = 3'd0,
        REG_DIR  = 3'd1,
        REG_ASG  = 3'd2,
        REG_SPC  = 3'd3,
        REG_EDGE = 3'd4,
        REG_MASK = 3'd5,
        REG_PEND = 3'd6,
        REG_NONE = 3'd7
    } reg_sel_e;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
    parameter int NPINS  = 12,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] d,
    output logic [NPINS-1:0] q
);
    logic [NPINS-1:0] chain [STAGES];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= '0;
        else        chain[0] <= d;
    end

    for (genvar s = 1; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[s] <= '0;
            else        chain[s] <= chain[s-1];
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
    import gpio_port_pkg::*;
#(
    parameter int NPINS = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  dat_q,
    output logic [NPINS-1:0]  dir_q,
    output logic [NPINS-1:0]  asg_q,
    output logic [NPINS-1:0]  spc_q,
    output logic [NPINS-1:0]  edg_q,
    output logic [NPINS-1:0]  msk_q,
    output logic [NPINS-1:0]  clr_vec
);
    reg_sel_e sel;
    assign sel = reg_sel_e'(bus_addr);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dat_q <= '0;
            dir_q <= '0;
            asg_q <= '0;
            spc_q <= '0;
            edg_q <= '0;
            msk_q <= '0;
        end else if (bus_wr) begin
            unique case (sel)
                REG_DATA: dat_q <= bus_wdata;
                REG_DIR:  dir_q <= bus_wdata;
                REG_ASG:  asg_q <= bus_wdata;
                REG_SPC:  spc_q <= bus_wdata;
                REG_EDGE: edg_q <= bus_wdata;
                REG_MASK: msk_q <= bus_wdata;
                REG_PEND, REG_NONE: ;
            endcase
        end
    end

    assign clr_vec = (bus_wr && sel == REG_PEND) ? bus_wdata : '0;

    // R3
    data_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(bus_wr && sel == REG_DATA) |=> $stable(dat_q));

    // R10
    none_addr_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && sel == REG_NONE) |=> ($stable(dir_q) && $stable(asg_q) && $stable(msk_q)));
endmodule

// File: rtl/gpio_edge_irq.sv
module gpio_edge_irq #(
    parameter int NPINS = 12
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NPINS-1:0] level,
    input  logic [NPINS-1:0] elig,
    input  logic [NPINS-1:0] fall_only,
    input  logic [NPINS-1:0] mask,
    input  logic [NPINS-1:0] clr_vec,
    output logic [NPINS-1:0] pend,
    output logic             irq
);
    logic [NPINS-1:0] prev;
    logic [NPINS-1:0] hit;

    for (genvar i = 0; i < NPINS; i++) begin : g_pin
        logic rise_w, fall_w;
        assign rise_w = level[i] & ~prev[i];
        assign fall_w = ~level[i] & prev[i];
        assign hit[i] = elig[i] & (fall_only[i] ? fall_w : (rise_w | fall_w));

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                prev[i] <= 1'b0;
                pend[i] <= 1'b0;
            end else begin
                prev[i] <= level[i];
                pend[i] <= (pend[i] & ~clr_vec[i]) | hit[i];
            end
        end
    end

    assign irq = |(pend & mask);

    // R6
    pend_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pend & ~$past(pend) & ~$past(hit)) == '0));

    // R8
    pend_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(pend) & ~$past(clr_vec) & ~pend) == '0));

    // R9
    mask_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mask == '0) |-> !irq);
endmodule

// File: rtl/gpio_port.sv
module gpio_port
    import gpio_port_pkg::*;
#(
    parameter int NPINS       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [NPINS-1:0]  bus_wdata,
    output logic [NPINS-1:0]  bus_rdata,
    input  logic [NPINS-1:0]  pin_in,
    output logic [NPINS-1:0]  pin_out,
    output logic [NPINS-1:0]  pin_oe,
    output logic [NPINS-1:0]  periph_in,
    output logic              irq
);
    logic [NPINS-1:0] dat_q, dir_q, asg_q, spc_q, edg_q, msk_q, clr_vec;
    logic [NPINS-1:0] lvl, pend, gp_in, drive;

    gpio_regs #(.NPINS(NPINS)) u_regs (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .dat_q(dat_q), .dir_q(dir_q), .asg_q(asg_q),
        .spc_q(spc_q), .edg_q(edg_q), .msk_q(msk_q), .clr_vec(clr_vec)
    );

    gpio_sync #(.NPINS(NPINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d(pin_in), .q(lvl)
    );

    assign gp_in = ~asg_q & ~dir_q;
    assign drive = dir_q & ~asg_q;

    gpio_edge_irq #(.NPINS(NPINS)) u_irq (
        .clk(clk), .rst_n(rst_n), .level(lvl), .elig(gp_in),
        .fall_only(edg_q), .mask(msk_q), .clr_vec(clr_vec),
        .pend(pend), .irq(irq)
    );

    assign pin_out   = dat_q;
    assign pin_oe    = drive;
    assign periph_in = lvl & (asg_q | (spc_q & gp_in));

    always_comb begin
        unique case (reg_sel_e'(bus_addr))
            REG_DATA: bus_rdata = (drive & dat_q) | (~drive & lvl);
            REG_DIR:  bus_rdata = dir_q;
            REG_ASG:  bus_rdata = asg_q;
            REG_SPC:  bus_rdata = spc_q;
            REG_EDGE: bus_rdata = edg_q;
            REG_MASK: bus_rdata = msk_q;
            REG_PEND: bus_rdata = pend;
            REG_NONE: bus_rdata = '0;
        endcase
    end

    // R2
    no_drive_assigned_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((pin_oe & asg_q) == '0));

    // R5
    periph_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((periph_in & ~asg_q & ~spc_q) == '0));
endmodule

// File: tb/gpio_port_tb.sv
module gpio_port_tb;
    localparam int N = 12;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         bus_wr = 1'b0;
    logic [2:0]   bus_addr = '0;
    logic [N-1:0] bus_wdata = '0;
    logic [N-1:0] bus_rdata, pin_out, pin_oe, periph_in;
    logic [N-1:0] pin_in = '0;
    logic         irq;

    int total = 0;
    int bad = 0;
    bit done = 0;

    logic [N-1:0] m_dat, m_dir, m_asg, m_spc, m_edg, m_msk, m_pend, cur;

    gpio_port #(.NPINS(N)) u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pin_in(pin_in),
        .pin_out(pin_out), .pin_oe(pin_oe), .periph_in(periph_in), .irq(irq)
    );

    always #4 clk = ~clk;

    task automatic chk(input string req, input logic [N-1:0] act, input logic [N-1:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] a, input logic [N-1:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [N-1:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    function automatic logic [N-1:0] exp_data();
        logic [N-1:0] drv = m_dir & ~m_asg;
        return (drv & m_dat) | (~drv & cur);
    endfunction

    function automatic logic [N-1:0] exp_hit(input logic [N-1:0] o, input logic [N-1:0] n);
        logic [N-1:0] elig = ~m_asg & ~m_dir;
        return elig & ((m_edg & o & ~n) | (~m_edg & (o ^ n)));
    endfunction

    task automatic set_pins(input logic [N-1:0] n);
        @(negedge clk);
        m_pend = m_pend | exp_hit(cur, n);
        pin_in = n;
        cur = n;
        repeat (3) @(negedge clk);
    endtask

    task automatic check_all(input string tag);
        logic [N-1:0] v;
        rd(3'd0, v); chk({"R4 data ", tag}, v, exp_data());
        rd(3'd6, v); chk({"R7 pend ", tag}, v, m_pend);
        chk({"R9 irq ", tag}, {{(N-1){1'b0}}, irq}, {{(N-1){1'b0}}, |(m_pend & m_msk)});
        chk({"R2 oe ", tag}, pin_oe, m_dir & ~m_asg);
        chk({"R2 out ", tag}, pin_out, m_dat);
        chk({"R5 periph ", tag}, periph_in, cur & (m_asg | (m_spc & ~m_asg & ~m_dir)));
    endtask

    initial begin
        logic [N-1:0] v;
        void'($urandom(32'h5eed1234));
        {m_dat, m_dir, m_asg, m_spc, m_edg, m_msk, m_pend, cur} = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state of all registers and outputs
        for (int a = 0; a < 8; a++) begin
            rd(3'(a), v); chk("R1 reg reset", v, '0);
        end
        chk("R1 oe", pin_oe, '0);
        chk("R1 irq", {{(N-1){1'b0}}, irq}, '0);

        // R3: latch written while input, appears when pin made output
        wr(3'd0, 12'hA5C);
        m_dat = 12'hA5C;
        chk("R3 latch while input", pin_oe, '0);
        rd(3'd0, v); chk("R3 read is pin level", v, '0);
        wr(3'd1, 12'h0F0); m_dir = 12'h0F0;
        rd(3'd0, v); chk("R3 driven latch", v, 12'h050);

        // R10: address 7 reads zero and writes are ignored
        wr(3'd7, '1);
        rd(3'd7, v); chk("R10 addr7 read", v, '0);
        rd(3'd1, v); chk("R10 addr7 no write", v, m_dir);
        rd(3'd5, v); chk("R10 addr7 mask", v, '0);

        // R6/R7: assigned pin blocked, special pin still interrupts
        wr(3'd1, '0); m_dir = '0;
        wr(3'd2, 12'h001); m_asg = 12'h001;
        wr(3'd3, 12'h002); m_spc = 12'h002;
        wr(3'd5, 12'h003); m_msk = 12'h003;
        set_pins(12'h003);
        check_all("R6 special vs assigned");

        // R8: clear and new edge on same cycle -> set wins
        wr(3'd6, m_pend); m_pend = '0;
        @(negedge clk);
        pin_in = 12'h001; // pin 1 falls (both-edge mode)
        cur = 12'h001;
        @(negedge clk);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = 3'd6; bus_wdata = 12'h002;
        @(negedge clk);
        bus_wr = 1'b0;
        m_pend = 12'h002;
        rd(3'd6, v); chk("R8 set beats clear", v, 12'h002);
        wr(3'd6, 12'h002); m_pend = '0;
        rd(3'd6, v); chk("R8 clear", v, '0);

        // Random configurations and pin patterns
        for (int it = 0; it < 60; it++) begin
            m_dat = N'($urandom); wr(3'd0, m_dat);
            m_dir = N'($urandom) & N'($urandom); wr(3'd1, m_dir);
            m_asg = N'($urandom) & N'($urandom); wr(3'd2, m_asg);
            m_spc = N'($urandom); wr(3'd3, m_spc);
            m_edg = N'($urandom); wr(3'd4, m_edg);
            m_msk = N'($urandom) & N'($urandom); wr(3'd5, m_msk);
            set_pins(N'($urandom));
            check_all("R7 random");
            begin
                logic [N-1:0] c = N'($urandom);
                wr(3'd6, c);
                m_pend = m_pend & ~c;
                rd(3'd6, v); chk("R8 partial clear", v, m_pend);
            end
        end

        done = 1;
    end

    initial begin
        for (int cyc = 0; cyc < 100000 && !done; cyc++) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog actual=hung expected=done");
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule